// File: doc/BRIEF.md
# Channel Interface Stall Monitor

This block watches the handshake between an I/O channel and one attached device. It raises a sticky interface control check when the device stops answering. Two timers run one after the other. The short one covers the time before a connection exists: the channel is waiting for a connection, for select-in to come back, or for any response at all. Once the device is connected, the long one covers the wait for the device's next response or its request to disconnect.

Two configuration bits decide whether the monitor is armed. These bits describe how far the channel borrows the processor's control logic. The first bit arms the monitor for every interface operation except polling while the channel is idle. The second bit arms it for everything, idle polling included. When neither bit covers the current operation, both timers stay at zero and the flag cannot be set.

Both limits are computed in clock cycles from the clock frequency and two durations given in nanoseconds. The defaults are roughly 32 µs for the short timer and 500 ms for the long one. Once the flag is set, it holds until the clear input is pulsed.

Top module: `chan_stall_monitor`

## Requirements
- R1: After reset `icc_flag` is 0, and both timers restart from zero.
- R2: The short timer runs while the monitor is armed, `dev_conn` is 0, `dev_sel_in` and `dev_resp` are 0, and either `op_wait` is 1 or idle polling is present. If it runs for SHORT_LIM consecutive cycles, `icc_flag` is 1 from the next cycle on.
- R3: A cycle with `dev_sel_in` or `dev_resp` at 1, or one in which the short timer's run condition is otherwise false, returns the short timer to zero. A wait that is broken before SHORT_LIM cycles never sets the flag.
- R4: The long timer runs while the monitor is armed, `dev_conn` is 1, and `dev_resp` and `dev_disc` are both 0. If it runs for LONG_LIM consecutive cycles, the flag is set.
- R5: A cycle with `dev_resp` or `dev_disc` at 1 during a connection returns the long timer to zero.
- R6: When `dev_conn` rises, the short timer stops and the long timer starts from zero. The cycles already spent in the short wait do not count toward the long limit. A connection that is present before any short wait begins is timed by the long timer alone.
- R7: Idle polling means `poll_ind` is 1 while `op_wait`, `dev_conn`, `dev_sel_in`, `dev_resp` and `dev_disc` are all 0. With `cfg_share_poll` at 0, idle polling is never timed.
- R8: With `cfg_share_poll` at 1, idle polling is timed by the short timer. In that case `cfg_share_ctl` does not matter.
- R9: With both configuration bits at 0, no stimulus sets the flag.
- R10: Once set, `icc_flag` stays at 1 until a cycle with `icc_clr` at 1, which returns it to 0 the next cycle.
- R11: If a timer expires in the same cycle that `icc_clr` is 1, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_share_ctl | input | 1 | Arms the monitor for all operations except idle polling |
| cfg_share_poll | input | 1 | Arms the monitor for all operations including idle polling |
| op_wait | input | 1 | The channel has started an interface operation and is waiting on the device |
| poll_ind | input | 1 | Polling indication from the channel |
| dev_conn | input | 1 | A device is connected |
| dev_sel_in | input | 1 | Select-in has returned |
| dev_resp | input | 1 | The device gives a response of any kind |
| dev_disc | input | 1 | The device asks to disconnect |
| icc_clr | input | 1 | Clears the check flag |
| icc_flag | output | 1 | Sticky interface control check |

## Verification
A timer can expire in the same cycle that software pulses `icc_clr`. The bench sets this up on purpose: it holds a short wait until the cycle its count reaches the limit and drives the clear pulse in exactly that cycle. The expected result is that the flag is still 1 afterwards. A second coincidence is `dev_conn` rising while the short timer is close to its limit. The bench checks that the flag stays 0, because the count hands over to a long timer that starts from zero.

// File: rtl/chan_stall_monitor.sv
module chan_stall_monitor #(
  parameter int     CLK_MHZ  = 125,
  parameter longint SHORT_NS = 32000,
  parameter longint LONG_NS  = 500000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_share_ctl,
  input  logic cfg_share_poll,
  input  logic op_wait,
  input  logic poll_ind,
  input  logic dev_conn,
  input  logic dev_sel_in,
  input  logic dev_resp,
  input  logic dev_disc,
  input  logic icc_clr,
  output logic icc_flag
);

  localparam longint SHORT_LIM = (SHORT_NS * CLK_MHZ) / 1000;
  localparam longint LONG_LIM  = (LONG_NS * CLK_MHZ) / 1000;
  localparam int     SW = $clog2(SHORT_LIM + 1);
  localparam int     LW = $clog2(LONG_LIM + 1);

  logic          idle_poll, armed, short_run, long_run;
  logic          short_hit, long_hit, expire;
  logic [SW-1:0] short_cnt;
  logic [LW-1:0] long_cnt;

  assign idle_poll = poll_ind & ~op_wait & ~dev_conn & ~dev_sel_in & ~dev_resp & ~dev_disc;
  assign armed     = idle_poll ? cfg_share_poll : (cfg_share_ctl | cfg_share_poll);
  assign short_run = armed & ~dev_conn & (op_wait | idle_poll) & ~dev_sel_in & ~dev_resp;
  assign long_run  = armed & dev_conn & ~dev_resp & ~dev_disc;

  assign short_hit = short_run && (short_cnt == SW'(SHORT_LIM - 1));
  assign long_hit  = long_run && (long_cnt == LW'(LONG_LIM - 1));
  assign expire    = short_hit | long_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       short_cnt <= '0;
    else if (!short_run || short_hit) short_cnt <= '0;
    else                              short_cnt <= short_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     long_cnt <= '0;
    else if (!long_run || long_hit) long_cnt <= '0;
    else                            long_cnt <= long_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       icc_flag <= 1'b0;
    else if (expire)  icc_flag <= 1'b1;
    else if (icc_clr) icc_flag <= 1'b0;
  end

endmodule

module chan_stall_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_share_ctl,
  input logic cfg_share_poll,
  input logic op_wait,
  input logic poll_ind,
  input logic dev_conn,
  input logic dev_sel_in,
  input logic dev_resp,
  input logic dev_disc,
  input logic icc_clr,
  input logic icc_flag,
  input logic short_run,
  input logic long_run
);

  logic poll_only;
  assign poll_only = poll_ind & ~op_wait & ~dev_conn & ~dev_sel_in & ~dev_resp & ~dev_disc;

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    icc_flag && !icc_clr |=> icc_flag);

  assert_disarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_share_ctl && !cfg_share_poll && !icc_flag |=> !icc_flag);

  assert_poll_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_only && !cfg_share_poll && !icc_flag |=> !icc_flag);

  assert_long_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_conn && (dev_resp || dev_disc) && !icc_flag |=> !icc_flag);

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(icc_flag) |-> $past(short_run || long_run));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_run && long_run));

endmodule

bind chan_stall_monitor chan_stall_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_share_ctl(cfg_share_ctl), .cfg_share_poll(cfg_share_poll),
  .op_wait(op_wait), .poll_ind(poll_ind), .dev_conn(dev_conn), .dev_sel_in(dev_sel_in),
  .dev_resp(dev_resp), .dev_disc(dev_disc), .icc_clr(icc_clr), .icc_flag(icc_flag),
  .short_run(short_run), .long_run(long_run)
);

// File: tb/chan_stall_monitor_test.sv
`timescale 1ns/1ps
module chan_stall_monitor_test;
  localparam int S = 8;
  localparam int L = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc = 0, sp = 0, opw = 0, pol = 0, con = 0, sel = 0, rsp = 0, dsc = 0, clr = 0;
  logic flag;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  chan_stall_monitor #(.CLK_MHZ(1), .SHORT_NS(8000), .LONG_NS(40000)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_share_ctl(sc), .cfg_share_poll(sp),
    .op_wait(opw), .poll_ind(pol), .dev_conn(con), .dev_sel_in(sel),
    .dev_resp(rsp), .dev_disc(dsc), .icc_clr(clr), .icc_flag(flag));

  int m_s = 0, m_l = 0;
  bit m_flag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = 0; m_l = 0; m_flag = 0;
    end else begin
      bit idle, arm, s_on, l_on, hit;
      idle = pol && !opw && !con && !sel && !rsp && !dsc;
      arm  = idle ? sp : (sc || sp);
      s_on = arm && !con && (opw || idle) && !sel && !rsp;
      l_on = arm && con && !rsp && !dsc;
      hit = 0;
      if (s_on) begin m_s++; if (m_s == S) begin hit = 1; m_s = 0; end end else m_s = 0;
      if (l_on) begin m_l++; if (m_l == L) begin hit = 1; m_l = 0; end end else m_l = 0;
      if (hit) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    checks++;
    if (flag !== m_flag) begin
      fails++;
      $display("FAIL %s cycle %0d: icc_flag actual %0b expected %0b", cur_req, cyc, flag, m_flag);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_flag(string req, logic e);
    checks++;
    if (flag !== e) begin
      fails++;
      $display("FAIL %s: icc_flag actual %0b expected %0b", req, flag, e);
    end
  endtask

  task automatic quiet();
    opw = 0; pol = 0; con = 0; sel = 0; rsp = 0; dsc = 0; clr = 0;
  endtask

  task automatic clear_flag();
    quiet(); clr = 1; run(1); clr = 0; run(1);
  endtask

  initial begin
    run(3);
    expect_flag("R1", 0);
    rst_n = 1;
    run(2);
    expect_flag("R1", 0);

    cur_req = "R2"; sc = 1; opw = 1;
    run(S - 1); expect_flag("R2", 0);
    run(1);     expect_flag("R2", 1);
    cur_req = "R10"; quiet(); run(12); expect_flag("R10", 1);
    clear_flag(); expect_flag("R10", 0);

    cur_req = "R3"; opw = 1; run(S - 2); sel = 1; run(1); sel = 0; run(S - 2);
    rsp = 1; run(1); rsp = 0; run(S - 2); opw = 0; run(2); opw = 1; run(S - 2);
    expect_flag("R3", 0); quiet(); run(2);

    cur_req = "R4"; con = 1;
    run(L - 1); expect_flag("R4", 0);
    run(1);     expect_flag("R4", 1);
    clear_flag();

    cur_req = "R5"; con = 1;
    for (int i = 0; i < 3; i++) begin run(L - 5); rsp = 1; run(1); rsp = 0; end
    run(L - 5); dsc = 1; run(1); dsc = 0; run(L - 5);
    expect_flag("R5", 0); quiet(); run(2);

    cur_req = "R6"; opw = 1; run(S - 1); con = 1; run(L - 1);
    expect_flag("R6", 0); run(1); expect_flag("R6", 1);
    clear_flag();
    cur_req = "R6"; con = 1; opw = 1; run(L - 1); expect_flag("R6", 0);
    quiet(); run(2);

    cur_req = "R7"; sc = 1; sp = 0; pol = 1; run(3 * S); expect_flag("R7", 0);
    quiet(); run(1);
    cur_req = "R8"; sc = 0; sp = 1; pol = 1;
    run(S - 1); expect_flag("R8", 0); run(1); expect_flag("R8", 1);
    clear_flag();

    cur_req = "R9"; sc = 0; sp = 0; opw = 1; run(3 * S); con = 1; opw = 0; run(L + 5);
    expect_flag("R9", 0); quiet(); run(2);

    cur_req = "R11"; sc = 1; opw = 1; run(S - 1); clr = 1; run(1); clr = 0;
    expect_flag("R11", 1);
    quiet(); run(3); expect_flag("R11", 1);
    clear_flag(); expect_flag("R10", 0);

    cur_req = "R1"; opw = 1; run(S - 2); rst_n = 0; run(2); rst_n = 1; run(S - 1);
    expect_flag("R1", 0); run(1); expect_flag("R1", 1);

    quiet(); run(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule